// File: doc/BRIEF.md
# Threshold-Network Full Adder

This block adds two one-bit operands and a carry-in, giving a sum bit and a carry-out bit. It does not use the usual XOR and AND-OR gates. Instead it is a two-layer feed-forward network of hard-limit threshold units with fixed small integer weights.

Each unit multiplies its binary inputs by sign-magnitude weights using AND gates. It adds the signed products to a constant bias. It outputs 1 when that total is zero or positive. Three hidden units look at the operands, and two output units look at the hidden results.

The block is purely combinational and has no clock or reset. It drops in wherever a full-adder cell is expected.

Top module: `nn_full_adder`

## Requirements
- R1: `sum` equals the odd parity of `a`, `b` and `cin` for every input combination.
- R2: `cout` is 1 exactly when at least two of `a`, `b` and `cin` are 1.
- R3: The two-bit value {`cout`,`sum`} equals the arithmetic sum `a + b + cin` for all eight input combinations.
- R4: The outputs are a pure function of the present inputs. They take their new value in the same time step as an input change, without any clock edge, and they hold no memory of earlier inputs.
- R5: With all three inputs at 0, both outputs are 0.
- R6: With all three inputs at 1, both outputs are 1.
- R7: A unit fires when its weighted total plus bias is exactly zero. The weights below make this observable at the ports. The sum unit has weights -2, -1 and +2 on hidden units 0, 1 and 2, and bias 0. The hidden units have these weights over (a, b, cin):
  - unit 0: +1, 0, -3, bias 0
  - unit 1: -3, -3, +1, bias +2
  - unit 2: -1, -2, -2, bias +2

  For input pattern a=0, b=1, cin=0 the sum unit's total is exactly 0, so `sum` must be 1. The same holds for a=b=cin=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 1 | First operand bit |
| b | input | 1 | Second operand bit |
| cin | input | 1 | Carry input |
| sum | output | 1 | Sum bit, from the first output unit |
| cout | output | 1 | Carry output, from the second output unit |

## Verification
The block has no stored state. A wrong weight, a wrong sign bit or an off-by-one threshold therefore shows up at once, as a wrong `sum` or `cout` for a particular input pattern, in the same time step that the pattern is applied.

Driving all eight patterns exposes any such fault. The patterns whose totals land exactly on zero (0,1,0), (1,0,0) and (1,1,1) are the ones that catch a threshold moved from "at least zero" to "above zero". Walking the inputs through several changes within a single clock phase shows that no register has crept into the path.

// File: rtl/nn_fa_pkg.sv
package nn_fa_pkg;

    // Sign-magnitude weight: neg=1 means negative, mag in 0..3
    typedef struct packed {
        logic       neg;
        logic [1:0] mag;
    } smw_t;

    localparam int SMW_W    = 3;
    localparam int N_INPUT  = 3;
    localparam int N_HIDDEN = 3;
    localparam int N_OUTPUT = 2;

    function automatic logic [SMW_W-1:0] enc(input int w);
        int m;
        m = (w < 0) ? -w : w;
        return {(w < 0), m[1:0]};
    endfunction

    // Packing: unit j, input i lives at bits [(j*N_IN+i)*3 +: 3]
    localparam logic [SMW_W*N_INPUT*N_HIDDEN-1:0] HID_W = {
        enc(-2), enc(-2), enc(-1),   // hidden unit 2 : cin, b, a
        enc(1),  enc(-3), enc(-3),   // hidden unit 1
        enc(-3), enc(0),  enc(1)     // hidden unit 0
    };
    localparam logic [SMW_W*N_HIDDEN-1:0] HID_B = {enc(2), enc(2), enc(0)};

    localparam logic [SMW_W*N_HIDDEN*N_OUTPUT-1:0] OUT_W = {
        enc(-3), enc(0),  enc(0),    // carry unit : h2, h1, h0
        enc(2),  enc(-1), enc(-2)    // sum unit
    };
    localparam logic [SMW_W*N_OUTPUT-1:0] OUT_B = {enc(2), enc(0)};

endpackage

// File: rtl/nn_sm_and.sv
module nn_sm_and
    import nn_fa_pkg::*;
(
    input  logic x,
    input  smw_t w,
    output smw_t p
);
    // Binary input times sign-magnitude weight: three AND gates
    assign p.mag = {2{x}} & w.mag;
    assign p.neg = x & w.neg;
endmodule

// File: rtl/nn_neuron.sv
module nn_neuron
    import nn_fa_pkg::*;
#(
    parameter int                      N_IN   = 3,
    parameter logic [SMW_W*N_IN-1:0]   W_CODE = '0,
    parameter logic [SMW_W-1:0]        B_CODE = '0
) (
    input  logic [N_IN-1:0] x,
    output logic            fire
);
    localparam int ACC_W = $clog2(3*N_IN + 4) + 1;
    localparam logic signed [ACC_W-1:0] BIAS_MAG = ACC_W'(B_CODE[1:0]);
    localparam logic signed [ACC_W-1:0] BIAS_V   = B_CODE[2] ? -BIAS_MAG : BIAS_MAG;
    localparam logic                    BIAS_NN  = !B_CODE[2] || (B_CODE[1:0] == 2'd0);

    smw_t prod [N_IN];

    generate
        for (genvar gi = 0; gi < N_IN; gi++) begin : g_prod
            nn_sm_and u_and (
                .x (x[gi]),
                .w (W_CODE[SMW_W*gi +: SMW_W]),
                .p (prod[gi])
            );
        end
    endgenerate

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] term;

    always_comb begin
        acc  = BIAS_V;
        term = '0;
        for (int i = 0; i < N_IN; i++) begin
            term = {{(ACC_W-2){1'b0}}, prod[i].mag};
            acc  = prod[i].neg ? (acc - term) : (acc + term);
        end
        fire = ~acc[ACC_W-1];
    end

    // R7: with no input active only the bias counts; non-negative bias fires
    always_comb begin
        if (!$isunknown(x) && (x == '0)) begin
            a_r7_idle_bias_fire: assert (fire == BIAS_NN)
                else $error("neuron idle fire mismatch");
        end
    end
endmodule

// File: rtl/nn_layer.sv
module nn_layer
    import nn_fa_pkg::*;
#(
    parameter int                            N_IN   = 3,
    parameter int                            N_OUT  = 3,
    parameter logic [SMW_W*N_IN*N_OUT-1:0]   W_CODE = '0,
    parameter logic [SMW_W*N_OUT-1:0]        B_CODE = '0
) (
    input  logic [N_IN-1:0]  x,
    output logic [N_OUT-1:0] y
);
    localparam int ROW_W = SMW_W * N_IN;

    generate
        for (genvar gj = 0; gj < N_OUT; gj++) begin : g_unit
            nn_neuron #(
                .N_IN   (N_IN),
                .W_CODE (W_CODE[ROW_W*gj +: ROW_W]),
                .B_CODE (B_CODE[SMW_W*gj +: SMW_W])
            ) u_neuron (
                .x    (x),
                .fire (y[gj])
            );
        end
    endgenerate
endmodule

// File: rtl/nn_full_adder.sv
module nn_full_adder
    import nn_fa_pkg::*;
(
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic sum,
    output logic cout
);
    logic [N_INPUT-1:0]  in_vec;
    logic [N_HIDDEN-1:0] hid;
    logic [N_OUTPUT-1:0] out_vec;

    assign in_vec = {cin, b, a};

    nn_layer #(
        .N_IN   (N_INPUT),
        .N_OUT  (N_HIDDEN),
        .W_CODE (HID_W),
        .B_CODE (HID_B)
    ) u_hidden (
        .x (in_vec),
        .y (hid)
    );

    nn_layer #(
        .N_IN   (N_HIDDEN),
        .N_OUT  (N_OUTPUT),
        .W_CODE (OUT_W),
        .B_CODE (OUT_B)
    ) u_output (
        .x (hid),
        .y (out_vec)
    );

    assign sum  = out_vec[0];
    assign cout = out_vec[1];

    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            a_r1_sum_parity: assert (sum == (a ^ b ^ cin))
                else $error("sum not parity");
            a_r2_cout_majority: assert (cout == ((a & b) | (a & cin) | (b & cin)))
                else $error("cout not majority");
            a_r2_cout_vs_hidden: assert (cout == ~hid[2])
                else $error("carry unit disagrees with hidden unit 2");
            a_r3_arith_total: assert ({cout, sum} == (2'(a) + 2'(b) + 2'(cin)))
                else $error("total mismatch");
        end
    end
endmodule

// File: tb/tb_nn_full_adder.sv
module tb_nn_full_adder;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic a, b, cin;
    logic sum, cout;
    int   n_run  = 0;
    int   n_fail = 0;
    logic done   = 1'b0;

    nn_full_adder dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

    // {a, b, cin, cout, sum}
    localparam logic [4:0] VEC [8] = '{
        5'b000_00, 5'b001_01, 5'b010_01, 5'b011_10,
        5'b100_01, 5'b101_10, 5'b110_10, 5'b111_11
    };

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (a=%b b=%b cin=%b)",
                     req, act, exp, a, b, cin);
        end
    endtask

    task automatic drive(input logic [2:0] v);
        {a, b, cin} = v;
        #1;
    endtask

    initial begin
        {a, b, cin} = 3'b000;
        @(negedge clk);
        #1;
        chk("R5 all zero", {cout, sum}, 2'b00);

        // table walk
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            drive(VEC[i][4:2]);
            chk("R3 table", {cout, sum}, VEC[i][1:0]);
            chk("R1 parity", {1'b0, sum}, {1'b0, ^VEC[i][4:2]});
            chk("R2 majority", {1'b0, cout},
                {1'b0, (VEC[i][4] & VEC[i][3]) | (VEC[i][4] & VEC[i][2]) | (VEC[i][3] & VEC[i][2])});
        end

        // R3 arithmetic cross-check
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            drive(3'(v));
            chk("R3 arith", {cout, sum}, 2'(v[2]) + 2'(v[1]) + 2'(v[0]));
        end

        // R7 exact-zero threshold patterns
        @(negedge clk);
        drive(3'b010);
        chk("R7 net zero 010", {cout, sum}, 2'b01);
        drive(3'b100);
        chk("R7 net zero 100", {cout, sum}, 2'b01);
        drive(3'b111);
        chk("R7 net zero 111", {cout, sum}, 2'b11);
        chk("R6 all ones", {cout, sum}, 2'b11);

        // R4: several changes inside one clock phase, no edge in between
        @(posedge clk);
        #1;
        drive(3'b110);
        chk("R4 no clock 110", {cout, sum}, 2'b10);
        drive(3'b001);
        chk("R4 no clock 001", {cout, sum}, 2'b01);
        drive(3'b000);
        chk("R4 no memory 000", {cout, sum}, 2'b00);
        drive(3'b011);
        chk("R4 no memory 011", {cout, sum}, 2'b10);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule